// File: doc/BRIEF.md
# Modulo Timer Counter with Overflow Flag

This block is a free-running timer counter whose period is set by a modulo input. It runs in one of two shapes. In up-count mode it counts from zero to a terminal value and wraps back to zero. In center-aligned mode it climbs to the terminal value and then descends to zero, which gives a symmetric triangle suited to centered pulse-width modulation. A modulo input of zero selects the full-scale terminal value (all ones).

At the end of each period the block sets an overflow flag. In up-count mode that is the wrap to zero. In center-aligned mode it is the turnaround at the top. The flag drives a level interrupt request while the interrupt enable is high. Software reads the flag through a one-address status port. It clears the flag by reading the status while the flag is set and then writing zero to the flag bit. An overflow that lands between those two steps cancels the clear, so no period end is ever lost. The modulo input passes into an internal shadow copy. The copy follows the input while counting is stopped, and while running it is refreshed only at a period boundary.

Top module: `modTimer`

## Requirements
- R1: In up-count mode each enabled cycle adds one to the counter. When the counter is at or above the terminal value (the shadow modulo, or all ones when the shadow is zero), the next enabled cycle returns it to zero.
- R2: In up-count mode the overflow flag becomes 1 on the same clock edge where the counter returns to zero. This includes the full-scale case, where the counter passes from all ones to zero.
- R3: In center-aligned mode the counter rises to the terminal value, then falls one step per cycle to zero, then rises again. The flag is set on the edge where the counter leaves the terminal value downward. Reaching zero never sets it. Status bit 1 reads 1 while the counter is in the descending phase.
- R4: While count enable is low, the counter and the flag hold their values and no overflow occurs.
- R5: While counting is stopped, the shadow modulo follows the modulo input. While running, a new modulo value takes effect only at the next overflow edge.
- R6: Status bit 0 is the flag and bits 7:2 read 0. A status read while the flag is 1 arms a clear. A following write with the flag data bit at 0 clears the flag.
- R7: A zero write that has not been armed leaves the flag unchanged. A write with the data bit at 1 never changes the flag. Any write ends the armed state.
- R8: An overflow that occurs after the arming read and before the zero write disarms the clear, and the flag stays 1 after that write.
- R9: The interrupt request equals the flag while interrupt enable is 1, and is 0 while interrupt enable is 0.
- R10: Reset sets the counter to 0, the flag to 0, the armed state to off, the direction to counting up and the shadow modulo to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntEn | input | 1 | Count enable |
| centerMode | input | 1 | 1 selects center-aligned counting, 0 up-count |
| irqEn | input | 1 | Interrupt enable |
| modVal | input | WIDTH | Modulo value (0 means full scale) |
| busRd | input | 1 | Status read strobe |
| busWr | input | 1 | Status write strobe |
| busWrBit | input | 1 | Value written to the flag bit |
| busRdData | output | 8 | Status: bit 0 flag, bit 1 descending |
| count | output | WIDTH | Current counter value |
| ovfFlag | output | 1 | Overflow flag |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with WIDTH set to 8. At that width the full-scale wrap from all ones to zero occurs after 256 cycles, so the case is driven directly, and random modulo values of up to 12 produce many overflows in both modes. Short periods also make it frequent for an overflow to fall between an arming read and the zero write, and for modulo changes to land mid-period. Mode switches happen while the counter is in either direction.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int STATUS_W = 8;

  typedef struct packed {
    logic loadMod;
    logic stepUp;
    logic stepDown;
    logic wrapZero;
  } tmrStrobe_t;
endpackage

// File: rtl/tmrDatapath.sv
module tmrDatapath
  import modtmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [WIDTH-1:0] modVal,
  output logic [WIDTH-1:0] count,
  output logic             atTop,
  output logic             atZero
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cntQ;
  logic [WIDTH-1:0] shadowQ;
  logic [WIDTH-1:0] termVal;

  // zero modulo selects the full-scale terminal value
  assign termVal = (shadowQ == '0) ? '1 : shadowQ;
  assign atTop   = (cntQ >= termVal);
  assign atZero  = (cntQ == '0);
  assign count   = cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      shadowQ <= '0;
    end else begin
      if (strb.loadMod) shadowQ <= modVal;
      if (strb.wrapZero)      cntQ <= '0;
      else if (strb.stepUp)   cntQ <= cntQ + ONE;
      else if (strb.stepDown) cntQ <= cntQ - ONE;
    end
  end
endmodule

// File: rtl/tmrControl.sv
module tmrControl
  import modtmr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cntEn,
  input  logic                centerMode,
  input  logic                irqEn,
  input  logic                atTop,
  input  logic                atZero,
  input  logic                busRd,
  input  logic                busWr,
  input  logic                busWrBit,
  output tmrStrobe_t          strb,
  output logic                dirUp,
  output logic                ovfFlag,
  output logic                irq,
  output logic [STATUS_W-1:0] busRdData
);
  logic ovfEvt;
  logic nextUp;
  logic armedQ;
  logic flagQ;
  logic upQ;

  // sequencing of the counter and detection of period ends
  always_comb begin
    strb   = '0;
    ovfEvt = 1'b0;
    nextUp = upQ;
    if (!cntEn) begin
      strb.loadMod = 1'b1;
    end else if (!centerMode) begin
      if (atTop) begin
        strb.wrapZero = 1'b1;
        strb.loadMod  = 1'b1;
        ovfEvt        = 1'b1;
      end else begin
        strb.stepUp = 1'b1;
      end
    end else if (upQ) begin
      if (atTop) begin
        strb.stepDown = 1'b1;
        strb.loadMod  = 1'b1;
        ovfEvt        = 1'b1;
        nextUp        = 1'b0;
      end else begin
        strb.stepUp = 1'b1;
      end
    end else begin
      if (atZero) begin
        strb.stepUp = 1'b1;
        nextUp      = 1'b1;
      end else begin
        strb.stepDown = 1'b1;
      end
    end
    if (!centerMode) nextUp = 1'b1;
  end

  // flag with the read-then-zero-write clear; a new event disarms
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ    <= 1'b1;
      flagQ  <= 1'b0;
      armedQ <= 1'b0;
    end else begin
      upQ <= nextUp;
      if (ovfEvt) begin
        flagQ  <= 1'b1;
        armedQ <= 1'b0;
      end else if (busWr) begin
        armedQ <= 1'b0;
        if (armedQ && !busWrBit) flagQ <= 1'b0;
      end else if (busRd && flagQ) begin
        armedQ <= 1'b1;
      end
    end
  end

  assign dirUp     = upQ;
  assign ovfFlag   = flagQ;
  assign irq       = flagQ & irqEn;
  assign busRdData = {{(STATUS_W-2){1'b0}}, ~upQ, flagQ};
endmodule

// File: rtl/modTimer.sv
module modTimer
  import modtmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cntEn,
  input  logic                centerMode,
  input  logic                irqEn,
  input  logic [WIDTH-1:0]    modVal,
  input  logic                busRd,
  input  logic                busWr,
  input  logic                busWrBit,
  output logic [STATUS_W-1:0] busRdData,
  output logic [WIDTH-1:0]    count,
  output logic                ovfFlag,
  output logic                irq
);
  tmrStrobe_t strb;
  logic       atTop;
  logic       atZero;
  logic       dirUp;

  tmrDatapath #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .modVal (modVal),
    .count  (count),
    .atTop  (atTop),
    .atZero (atZero)
  );

  tmrControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntEn      (cntEn),
    .centerMode (centerMode),
    .irqEn      (irqEn),
    .atTop      (atTop),
    .atZero     (atZero),
    .busRd      (busRd),
    .busWr      (busWr),
    .busWrBit   (busWrBit),
    .strb       (strb),
    .dirUp      (dirUp),
    .ovfFlag    (ovfFlag),
    .irq        (irq),
    .busRdData  (busRdData)
  );
endmodule

// File: rtl/modTimerChk.sv
module modTimerChk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEn,
  input logic             centerMode,
  input logic             busWr,
  input logic             busWrBit,
  input logic [WIDTH-1:0] count,
  input logic             ovfFlag,
  input logic             atTop,
  input logic             dirUp
);
  // R2: an up-mode wrap returns the counter to zero with the flag set
  a_r2_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !centerMode && atTop) |=> (count == '0 && ovfFlag));

  // R3: the turnaround at the top sets the flag and starts the descent
  a_r3_turn_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && centerMode && dirUp && atTop) |=> (ovfFlag && !dirUp));

  // R3: reaching zero while descending raises no flag
  a_r3_no_flag_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && centerMode && !dirUp && count == '0 && !ovfFlag) |=> !ovfFlag);

  // R4: the counter holds while stopped
  a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(count));

  // R6: the flag only drops after a zero write
  a_r6_clear_needs_zero_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(busWr && !busWrBit));
endmodule

bind modTimer modTimerChk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cntEn      (cntEn),
  .centerMode (centerMode),
  .busWr      (busWr),
  .busWrBit   (busWrBit),
  .count      (count),
  .ovfFlag    (ovfFlag),
  .atTop      (atTop),
  .dirUp      (dirUp)
);

// File: tb/tb_modTimer.sv
`timescale 1ns/1ps
module tb_modTimer;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntEn = 1'b0, centerMode = 1'b0, irqEn = 1'b0;
  logic busRd = 1'b0, busWr = 1'b0, busWrBit = 1'b0;
  logic [W-1:0] modVal = '0;
  logic [7:0]   busRdData;
  logic [W-1:0] count;
  logic         ovfFlag, irq;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference state
  logic [W-1:0] mCnt, mSh;
  logic mUp, mFlag, mArm;

  modTimer #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .centerMode(centerMode),
    .irqEn(irqEn), .modVal(modVal), .busRd(busRd), .busWr(busWr),
    .busWrBit(busWrBit), .busRdData(busRdData), .count(count),
    .ovfFlag(ovfFlag), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [W-1:0] termOf(input logic [W-1:0] s);
    return (s == '0) ? '1 : s;
  endfunction

  function automatic logic [7:0] expStatus();
    return {6'b0, ~mUp, mFlag};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmpAll(input string tag);
    chk({tag, " count"},  int'(count),     int'(mCnt));
    chk({tag, " flag"},   int'(ovfFlag),   int'(mFlag));
    chk({tag, " irq R9"}, int'(irq),       int'(mFlag & irqEn));
    chk({tag, " status"}, int'(busRdData), int'(expStatus()));
  endtask

  // one clock: predict from requirements, step, compare
  task automatic cyc(input string tag);
    logic [W-1:0] nCnt, nSh, t;
    logic nUp, nFlag, nArm, evt;
    nCnt = mCnt; nSh = mSh; nUp = mUp; nFlag = mFlag; nArm = mArm; evt = 1'b0;
    t = termOf(mSh);
    if (!cntEn) nSh = modVal;
    else if (!centerMode) begin
      if (mCnt >= t) begin nCnt = '0; evt = 1'b1; nSh = modVal; end
      else nCnt = mCnt + 1'b1;
    end else if (mUp) begin
      if (mCnt >= t) begin nCnt = mCnt - 1'b1; nUp = 1'b0; evt = 1'b1; nSh = modVal; end
      else nCnt = mCnt + 1'b1;
    end else begin
      if (mCnt == '0) begin nCnt = 1; nUp = 1'b1; end
      else nCnt = mCnt - 1'b1;
    end
    if (!centerMode) nUp = 1'b1;
    if (evt) begin nFlag = 1'b1; nArm = 1'b0; end
    else if (busWr) begin nArm = 1'b0; if (mArm && !busWrBit) nFlag = 1'b0; end
    else if (busRd && mFlag) nArm = 1'b1;
    @(posedge clk);
    #1;
    mCnt = nCnt; mSh = nSh; mUp = nUp; mFlag = nFlag; mArm = nArm;
    busRd = 1'b0; busWr = 1'b0; busWrBit = 1'b0;
    cmpAll(tag);
  endtask

  task automatic clearFlag(input string tag);
    busRd = 1'b1; cyc(tag);
    busWr = 1'b1; busWrBit = 1'b0; cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    mCnt = '0; mSh = '0; mUp = 1'b1; mFlag = 1'b0; mArm = 1'b0;
    // R10: reset state
    chk("R10 count", int'(count), 0);
    chk("R10 flag", int'(ovfFlag), 0);
    chk("R10 irq", int'(irq), 0);
    chk("R10 status", int'(busRdData), 0);
    rstN = 1'b1;

    // R1/R2 full scale: modulo 0 wraps from all ones
    modVal = '0; cyc("R5 load");
    cntEn = 1'b1;
    for (int i = 0; i < 255; i++) cyc("R1 full");
    chk("R1 at full scale", int'(count), 255);
    chk("R2 no flag yet", int'(ovfFlag), 0);
    cyc("R2 wrap");
    chk("R2 wrapped count", int'(count), 0);
    chk("R2 flag set", int'(ovfFlag), 1);

    // R9: irq follows enable
    cntEn = 1'b0;
    cyc("R9 off");
    chk("R9 irq masked", int'(irq), 0);
    irqEn = 1'b1; cyc("R9 on");
    chk("R9 irq level", int'(irq), 1);

    // R7: unarmed zero write and one-write leave the flag
    busWr = 1'b1; busWrBit = 1'b0; cyc("R7 unarmed");
    chk("R7 unarmed zero write", int'(ovfFlag), 1);
    busRd = 1'b1; cyc("R7 arm");
    busWr = 1'b1; busWrBit = 1'b1; cyc("R7 one write");
    chk("R7 one write", int'(ovfFlag), 1);
    busWr = 1'b1; busWrBit = 1'b0; cyc("R7 disarmed");
    chk("R7 arm consumed", int'(ovfFlag), 1);

    // R6: proper clear
    clearFlag("R6");
    chk("R6 flag cleared", int'(ovfFlag), 0);
    chk("R6 status", int'(busRdData), 0);
    chk("R9 irq drops", int'(irq), 0);

    // R8: overflow between the read and the zero write
    modVal = 8'd4; cyc("R5 stopped load");
    cntEn = 1'b1;
    for (int i = 0; i < 8 && !mFlag; i++) cyc("R8 run");
    busRd = 1'b1; cyc("R8 arm");
    for (int i = 0; i < 6; i++) cyc("R8 new event");
    busWr = 1'b1; busWrBit = 1'b0; cyc("R8 write");
    chk("R8 clear cancelled", int'(ovfFlag), 1);

    // R5: modulo change mid-period
    cntEn = 1'b0; clearFlag("R5 clr");
    cntEn = 1'b1;
    while (count != 8'd1) cyc("R5 align");
    modVal = 8'd2;
    cyc("R5 a"); cyc("R5 b"); cyc("R5 c");
    chk("R5 old modulo kept", int'(count), 4);
    cyc("R5 wrap");
    chk("R5 wrap", int'(count), 0);
    cyc("R5 d"); cyc("R5 e"); cyc("R5 f");
    chk("R5 new modulo", int'(count), 0);

    // R3: center-aligned, no flag at zero
    cntEn = 1'b0; modVal = 8'd3; cyc("R3 load");
    clearFlag("R3 clr");
    centerMode = 1'b1; cntEn = 1'b1;
    for (int i = 0; i < 10 && !mFlag; i++) cyc("R3 climb");
    chk("R3 after turn", int'(count), 2);
    chk("R3 descending", int'(busRdData[1]), 1);
    cntEn = 1'b0; clearFlag("R3 clr2"); cntEn = 1'b1;
    while (count != '0) cyc("R3 descend");
    chk("R3 no flag at zero", int'(ovfFlag), 0);
    cyc("R3 rise");
    chk("R3 rises", int'(count), 1);

    // R4: stopped counter holds
    cntEn = 1'b0;
    for (int i = 0; i < 4; i++) cyc("R4 hold");
    chk("R4 held", int'(count), 1);

    // constrained random, checked against the reference every cycle
    for (int i = 0; i < 4000; i++) begin
      cntEn = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 99) == 0) centerMode = ~centerMode;
      if ($urandom_range(0, 19) == 0) modVal = W'($urandom_range(0, 12));
      if ($urandom_range(0, 29) == 0) irqEn = ~irqEn;
      case ($urandom_range(0, 7))
        0: busRd = 1'b1;
        1: begin busWr = 1'b1; busWrBit = 1'b0; end
        2: begin busWr = 1'b1; busWrBit = 1'($urandom_range(0, 1)); end
        default: ;
      endcase
      cyc("RND R1/R3/R6/R8");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule